// File: doc/BRIEF.md
# Microcontroller Power-Saving Mode Controller

This block is the power-management logic of a small 8-bit microcontroller. The CPU writes a power-control register through a simple write port. Bit 0 of that register asks for idle mode and bit 1 asks for power-down mode. The block turns the current mode into two clock enables: one for the CPU core and one for the peripherals, which covers the interrupt logic, the serial port and the timers. It also forces the address-latch strobe and the program-store strobe to a fixed level while a low-power mode is active.

Idle mode stops only the core. Any enabled pending interrupt ends it. Power-down stops every clock. The only thing that ends it is an external interrupt that is enabled and set to level-sensitive, and whose pin stays low for a minimum number of consecutive cycles on the free-running restart clock. When a low-power mode ends, the core clock enable comes back in the same cycle as a one-cycle accept pulse to the interrupt controller. Hardware reset always returns the block to full run.

Top module: `pwrSaveCtl`

## Requirements
- R1: A write with bit 1 set (for example 0x02 or 0x03) while running enters power-down on the next cycle. Bit 1 wins over bit 0 when both are set.
- R2: A write with only bit 0 set (0x01) while running enters idle. A write with both bits clear leaves the block running.
- R3: Running drives coreClkEn=1 and periphClkEn=1. Idle drives coreClkEn=0 and periphClkEn=1.
- R4: Power-down drives coreClkEn=0 and periphClkEn=0.
- R5: strobeForce is 0 while running and 1 in either low-power mode. aleLevel and psenLevel are 1 in idle and 0 in power-down.
- R6: In idle, any set bit of irqPending at a clock edge returns the block to running after that edge. wakeAccept is 1 for exactly that one following cycle, together with coreClkEn=1.
- R7: In power-down, irqPending has no effect. A low extIntN also has no effect unless extIntEnable=1 and extIntLevel=1.
- R8: In power-down, with extIntEnable=1 and extIntLevel=1, extIntN sampled low on WAKE_CYCLES consecutive edges (default 1024) returns the block to running after the last of those edges, with a one-cycle wakeAccept.
- R9: extIntN sampled high before the count completes restarts the count, so a new low run again needs the full WAKE_CYCLES edges.
- R10: Register writes made while in idle or power-down are ignored.
- R11: While rstN=0 the block is running with wakeAccept=0. Reset taken during a low-power mode leaves that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator restart clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| regWrEn | input | 1 | Power-control register write strobe |
| regWrData | input | 8 | Write data: bit 0 idle, bit 1 power-down |
| irqPending | input | NUM_IRQ | Enabled pending interrupt requests |
| extIntN | input | 1 | External interrupt pin, active low |
| extIntEnable | input | 1 | External interrupt is enabled |
| extIntLevel | input | 1 | External interrupt is level-sensitive (1) or edge (0) |
| coreClkEn | output | 1 | CPU core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| strobeForce | output | 1 | Bus strobes overridden by the levels below |
| aleLevel | output | 1 | Forced address-latch strobe level |
| psenLevel | output | 1 | Forced program-store strobe level |
| wakeAccept | output | 1 | One-cycle pulse to the interrupt controller on wake |

## Verification
The bench targets the wake counter boundary. A low run one edge short of WAKE_CYCLES must not wake the block, and the full run must wake it on the exact edge. A design that is off by one either wakes early or wakes a cycle late. The bench also breaks a low run with one high sample and then tries again. A design that keeps its count across the break would wake too early on the second run. Value 0x03 checks that power-down wins, and a design with the wrong priority would stay in idle with the peripherals still clocked. Pending interrupts, and pin activity that is disabled or edge-configured, are applied during power-down to catch a design that wakes on the wrong sources.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } lpMode_e;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic wakeFire;
  } lpStrobe_t;
endpackage

// File: rtl/lpControl.sv
module lpControl
  import pwrsave_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic               pinQual,
  input  logic               cntDone,
  output lpMode_e            mode,
  output lpStrobe_t          strb
);
  lpMode_e modeNext;
  logic wakeIdle;
  logic wakePd;

  always_comb begin
    wakeIdle = (mode == MODE_IDLE) && (|irqPending);
    wakePd   = (mode == MODE_PDOWN) && pinQual && cntDone;
    strb.wakeFire = wakeIdle || wakePd;
    strb.cntInc   = (mode == MODE_PDOWN) && pinQual && !wakePd;
    strb.cntClr   = !strb.cntInc;
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_RUN: begin
        if (regWrEn) begin
          if (regWrData[PD_BIT])        modeNext = MODE_PDOWN;
          else if (regWrData[IDLE_BIT]) modeNext = MODE_IDLE;
        end
      end
      MODE_IDLE:  if (wakeIdle) modeNext = MODE_RUN;
      MODE_PDOWN: if (wakePd)   modeNext = MODE_RUN;
      default:    modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_RUN;
    else       mode <= modeNext;
  end

  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && regWrEn && regWrData[PD_BIT]) |=> (mode == MODE_PDOWN)); // R1
  AST_PD_HOLDS_UNTIL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PDOWN && !(pinQual && cntDone)) |=> (mode == MODE_PDOWN)); // R7
  AST_IDLE_HOLDS_WITHOUT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && !(|irqPending)) |=> (mode == MODE_IDLE)); // R10
endmodule

// File: rtl/lpDatapath.sv
module lpDatapath
  import pwrsave_pkg::*;
#(
  parameter int WAKE_CYCLES = 1024,
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  lpMode_e   mode,
  input  lpStrobe_t strb,
  output logic      cntDone,
  output logic      coreClkEn,
  output logic      periphClkEn,
  output logic      strobeForce,
  output logic      aleLevel,
  output logic      psenLevel,
  output logic      wakeAccept
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  logic [CNT_W-1:0] lowCnt;
  logic acceptQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowCnt <= '0;
    else if (strb.cntClr) lowCnt <= '0;
    else if (strb.cntInc) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptQ <= 1'b0;
    else       acceptQ <= strb.wakeFire;
  end

  always_comb begin
    cntDone     = (lowCnt == CNT_LAST);
    coreClkEn   = (mode == MODE_RUN);
    periphClkEn = (mode != MODE_PDOWN);
    strobeForce = (mode != MODE_RUN);
    aleLevel    = (mode == MODE_IDLE);
    psenLevel   = (mode == MODE_IDLE);
    wakeAccept  = acceptQ;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= CNT_LAST); // R8
  AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeAccept |=> !wakeAccept); // R6
  AST_ACCEPT_WITH_CORE: assert property (@(posedge clk) disable iff (!rstN)
    wakeAccept |-> coreClkEn); // R6
endmodule

// File: rtl/pwrSaveCtl.sv
module pwrSaveCtl
  import pwrsave_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic               extIntN,
  input  logic               extIntEnable,
  input  logic               extIntLevel,
  output logic               coreClkEn,
  output logic               periphClkEn,
  output logic               strobeForce,
  output logic               aleLevel,
  output logic               psenLevel,
  output logic               wakeAccept
);
  lpMode_e   mode;
  lpStrobe_t strb;
  logic      cntDone;
  logic      pinQual;

  assign pinQual = !extIntN && extIntEnable && extIntLevel;

  lpControl #(.NUM_IRQ(NUM_IRQ)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqPending(irqPending), .pinQual(pinQual), .cntDone(cntDone),
    .mode(mode), .strb(strb)
  );

  lpDatapath #(.WAKE_CYCLES(WAKE_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb), .cntDone(cntDone),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .strobeForce(strobeForce),
    .aleLevel(aleLevel), .psenLevel(psenLevel), .wakeAccept(wakeAccept)
  );

  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !periphClkEn |-> (!coreClkEn && strobeForce && !aleLevel && !psenLevel)); // R4
endmodule

// File: tb/pwrSaveCtl_tb_top.sv
module pwrSaveCtl_tb_top;
  localparam int NIRQ = 4;
  localparam int WAKE = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [NIRQ-1:0] irqPending = '0;
  logic extIntN = 1'b1;
  logic extIntEnable = 1'b0;
  logic extIntLevel = 1'b0;
  logic coreClkEn, periphClkEn, strobeForce, aleLevel, psenLevel, wakeAccept;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwrSaveCtl #(.NUM_IRQ(NIRQ), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqPending(irqPending), .extIntN(extIntN), .extIntEnable(extIntEnable),
    .extIntLevel(extIntLevel), .coreClkEn(coreClkEn), .periphClkEn(periphClkEn),
    .strobeForce(strobeForce), .aleLevel(aleLevel), .psenLevel(psenLevel),
    .wakeAccept(wakeAccept)
  );

  // mode: 0 run, 1 idle, 2 power-down
  function automatic logic [5:0] expObs(int m, bit acc);
    return {m == 0, m != 2, m != 0, m == 1, m == 1, acc};
  endfunction

  function automatic int modeAfterWrite(logic [7:0] v);
    if (v[1]) return 2;
    if (v[0]) return 1;
    return 0;
  endfunction

  task automatic check(string req, int m, bit acc);
    logic [5:0] act;
    logic [5:0] exp;
    act = {coreClkEn, periphClkEn, strobeForce, aleLevel, psenLevel, wakeAccept};
    exp = expObs(m, acc);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(logic [7:0] v);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = 8'h00;
  endtask

  task automatic holdLow(int n);
    extIntN = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic releaseHigh();
    extIntN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R11 reset state", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after reset release", 0, 0);

    writeReg(8'h00);
    check("R2 write zero stays running", 0, 0);

    writeReg(8'h01);
    check("R2 R3 R5 idle entered", 1, 0);
    writeReg(8'h02);
    check("R10 write ignored in idle", 1, 0);
    repeat (3) @(negedge clk);
    check("R3 idle holds without irq", 1, 0);

    irqPending = 4'b0010;
    @(negedge clk);
    irqPending = '0;
    check("R6 idle wake with accept", 0, 1);
    @(negedge clk);
    check("R6 accept single cycle", 0, 0);

    writeReg(8'h03);
    check("R1 R4 R5 power-down wins", 2, 0);

    irqPending = '1;
    extIntEnable = 1'b0;
    extIntLevel = 1'b1;
    holdLow(WAKE + 5);
    check("R7 pin disabled ignored", 2, 0);
    extIntEnable = 1'b1;
    extIntLevel = 1'b0;
    repeat (WAKE + 5) @(negedge clk);
    check("R7 edge mode ignored", 2, 0);
    releaseHigh();
    writeReg(8'h00);
    check("R10 write ignored in power-down", 2, 0);
    irqPending = '0;
    extIntLevel = 1'b1;

    holdLow(WAKE - 1);
    check("R8 one short no wake", 2, 0);
    releaseHigh();
    check("R9 break keeps power-down", 2, 0);
    holdLow(WAKE - 1);
    check("R9 count restarted", 2, 0);
    holdLow(1);
    check("R8 wake on last edge", 0, 1);
    releaseHigh();
    check("R8 accept single cycle", 0, 0);

    writeReg(8'h02);
    check("R1 power-down again", 2, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 reset exits power-down", 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int it = 0; it < 24; it++) begin
      logic [7:0] v;
      int m;
      v = 8'($urandom);
      m = modeAfterWrite(v);
      writeReg(v);
      check("R1 R2 random write", m, 0);
      if (m == 1) begin
        int w;
        w = int'($urandom % 5);
        repeat (w) @(negedge clk);
        check("R3 idle wait", 1, 0);
        irqPending = NIRQ'($urandom % ((1 << NIRQ) - 1) + 1);
        @(negedge clk);
        irqPending = '0;
        check("R6 random idle wake", 0, 1);
        @(negedge clk);
        check("R6 random accept end", 0, 0);
      end else if (m == 2) begin
        int len;
        extIntEnable = 1'b0;
        for (int k = 0; k < 4; k++) begin
          irqPending = NIRQ'($urandom);
          extIntN = 1'($urandom);
          @(negedge clk);
        end
        irqPending = '0;
        extIntEnable = 1'b1;
        releaseHigh();
        check("R7 random noise ignored", 2, 0);
        len = 1 + int'($urandom % (WAKE - 1));
        holdLow(len);
        releaseHigh();
        check("R9 random short run", 2, 0);
        holdLow(WAKE);
        check("R8 random full run wake", 0, 1);
        releaseHigh();
        check("R8 random accept end", 0, 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule